// File: doc/BRIEF.md
# Receive Frame and CRC Error Counter

This block keeps two running tallies for one receive path chosen from several: how many frames ended on that path, and how many of those frames ended with a bad CRC. Each receive path supplies a one-cycle end-of-frame strobe and, in the same cycle, a flag that is high when that frame's CRC check failed. The block computes no CRC itself.

A 3-bit path-select register controls the block. Writing a non-zero value both enables counting and picks the path. Writing zero stops counting and clears both tallies. Both counts are always visible as one 16-bit word. Reading that word never changes it, so software clears the tallies by writing zero to the select register.

Top module: `rx_frame_err_counter`

## Requirements
- R1: After reset both counts are zero, the select register is zero, and no path is monitored.
- R2: The read word carries the frame count in bits 15:8 and the CRC error count in bits 7:0.
- R3: Each end-of-frame strobe on the selected path adds one to the frame count. The new value is visible on the read word one clock after the strobe is sampled.
- R4: A strobe whose CRC error flag is high also adds one to the error count. A strobe whose flag is low leaves the error count unchanged.
- R5: Strobes and flags on paths that are not selected change neither count. While the select register is zero, no strobe changes either count.
- R6: Writing 000 to the select register clears both counts to zero on the next clock and disables counting.
- R7: Each count stops at 255 and never wraps. The frame count may keep rising while the error count is held at its limit.
- R8: Select value k (1 to 7) monitors input path bit k-1, so value 010 monitors path bit 1, the copper receive path. Writing one non-zero value over another keeps both counts and continues counting on the newly selected path.
- R9: While no strobe arrives and no select write occurs, the read word holds its value; observing it has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_wr | input | 1 | Write strobe for the path-select register |
| sel_wdata | input | 3 | Value written to the path-select register |
| path_eof | input | 7 | End-of-frame strobe per path; bit k-1 belongs to select value k |
| path_crc_err | input | 7 | CRC error flag per path, valid in the cycle its strobe is high |
| cnt_word | output | 16 | Frame count in [15:8], CRC error count in [7:0] |

## Verification
The assertions take the following for granted: the CRC error flag only matters alongside its strobe, and select writes and frame strobes never collide at the moment of a clear. Under that assumption the error count can never exceed the frame count, and the word stays still whenever the inputs are quiet. The directed stimulus changes inputs only on falling edges. It leaves idle cycles after every select write before sending strobes, and it waits out the internal reset release before its first write. This means no check relies on how a write and an event in the same cycle are ordered.

// File: rtl/frame_cnt_pkg.sv
package frame_cnt_pkg;
  localparam int SEL_W  = 3;
  localparam int CNT_W  = 8;
  localparam int N_PATH = (1 << SEL_W) - 1;
  localparam int WORD_W = 2 * CNT_W;

  typedef logic [SEL_W-1:0] path_sel_t;
  typedef logic [CNT_W-1:0] tally_t;

  localparam int TALLY_FRM = 0;
  localparam int TALLY_ERR = 1;
  localparam int N_TALLY   = 2;
endpackage

// File: rtl/reset_release_sync.sv
module reset_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/path_event_mux.sv
module path_event_mux
  import frame_cnt_pkg::*;
#(
  parameter int SW = SEL_W,
  localparam int NP = (1 << SW) - 1
) (
  input  logic [SW-1:0] sel,
  input  logic [NP-1:0] eof_vec,
  input  logic [NP-1:0] err_vec,
  output logic          frame_ev,
  output logic          err_ev
);
  always_comb begin
    frame_ev = 1'b0;
    err_ev   = 1'b0;
    for (int k = 1; k <= NP; k++) begin
      if (sel == SW'(k)) begin
        frame_ev = eof_vec[k-1];
        err_ev   = eof_vec[k-1] & err_vec[k-1];
      end
    end
  end
endmodule

// File: rtl/sat_tally.sv
module sat_tally #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  logic [W-1:0] value_q, value_d;
  logic         value_en;
  logic         at_top;

  assign at_top = &value_q;

  always_comb begin
    value_en = clr | (inc & ~at_top);
    value_d  = clr ? '0 : value_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value_q <= '0;
    else if (value_en) value_q <= value_d;
  end

  assign value = value_q;
endmodule

// File: rtl/rx_frame_err_counter.sv
module rx_frame_err_counter
  import frame_cnt_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W,
  localparam int NP = (1 << SW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic [SW-1:0] sel_wdata,
  input  logic [NP-1:0] path_eof,
  input  logic [NP-1:0] path_crc_err,
  output logic [2*CW-1:0] cnt_word
);
  logic          rst_n_int;
  logic [SW-1:0] sel_q;
  logic          sel_en;
  logic          clear_req;
  logic          frame_ev, err_ev;
  logic [N_TALLY-1:0] tally_inc;
  logic [CW-1:0] tally_val [N_TALLY];

  reset_release_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign sel_en    = sel_wr;
  assign clear_req = sel_wr & (sel_wdata == '0);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  sel_q <= '0;
    else if (sel_en) sel_q <= sel_wdata;
  end

  path_event_mux #(.SW(SW)) u_mux (
    .sel      (sel_q),
    .eof_vec  (path_eof),
    .err_vec  (path_crc_err),
    .frame_ev (frame_ev),
    .err_ev   (err_ev)
  );

  assign tally_inc[TALLY_FRM] = frame_ev;
  assign tally_inc[TALLY_ERR] = err_ev;

  for (genvar t = 0; t < N_TALLY; t++) begin : g_tally
    sat_tally #(.W(CW)) u_tally (
      .clk   (clk),
      .rst_n (rst_n_int),
      .clr   (clear_req),
      .inc   (tally_inc[t]),
      .value (tally_val[t])
    );
  end

  assign cnt_word = {tally_val[TALLY_FRM], tally_val[TALLY_ERR]};
endmodule

// File: rtl/rx_frame_err_counter_chk.sv
module rx_frame_err_counter_chk #(
  parameter int SW = 3,
  parameter int CW = 8,
  parameter int NP = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_wr,
  input logic [SW-1:0] sel_wdata,
  input logic [NP-1:0] path_eof,
  input logic [2*CW-1:0] cnt_word
);
  logic [CW-1:0] frm, err;
  assign frm = cnt_word[2*CW-1:CW];
  assign err = cnt_word[CW-1:0];

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && sel_wdata == '0) |=> (cnt_word == '0));

  // R7
  frame_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm == '1 && !(sel_wr && sel_wdata == '0)) |=> (frm == '1));

  // R4
  err_le_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err <= frm);

  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (path_eof == '0 && !sel_wr) |=> $stable(cnt_word));

  // R3
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_wr && sel_wdata == '0) |=> (frm == $past(frm) || frm == $past(frm) + CW'(1)));
endmodule

bind rx_frame_err_counter rx_frame_err_counter_chk #(.SW(SW), .CW(CW), .NP(NP)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_wr    (sel_wr),
  .sel_wdata (sel_wdata),
  .path_eof  (path_eof),
  .cnt_word  (cnt_word)
);

// File: tb/test_rx_frame_err_counter.sv
module test_rx_frame_err_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_wr;
  logic [2:0]  sel_wdata;
  logic [6:0]  path_eof;
  logic [6:0]  path_crc_err;
  logic [15:0] cnt_word;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_frame_err_counter i_rx_frame_err_counter (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .path_eof(path_eof), .path_crc_err(path_crc_err), .cnt_word(cnt_word)
  );

  task automatic check(string req, logic [15:0] exp);
    n_checks++;
    if (cnt_word !== exp) begin
      n_errors++;
      $display("FAIL %s: cnt_word=%h expected=%h", req, cnt_word, exp);
    end
  endtask

  task automatic write_sel(logic [2:0] v);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk); sel_wr = 1'b0; sel_wdata = '0;
    @(negedge clk);
  endtask

  task automatic frame(int bitn, logic bad);
    @(negedge clk); path_eof[bitn] = 1'b1; path_crc_err[bitn] = bad;
    @(negedge clk); path_eof = '0; path_crc_err = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sel_wr = 1'b0; sel_wdata = '0; path_eof = '0; path_crc_err = '0;
    repeat (4) @(negedge clk);
    check("R1 reset value", 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    frame(1, 1'b1);
    check("R1 no path monitored after reset", 16'h0000);
  endtask

  task automatic t_copper_count;
    write_sel(3'b010);
    frame(1, 1'b0);
    check("R3 first frame", 16'h0100);
    frame(1, 1'b1);
    check("R4 error frame", 16'h0201);
    frame(1, 1'b0); frame(1, 1'b0); frame(1, 1'b1);
    check("R2 word layout frame[15:8] err[7:0]", 16'h0502);
  endtask

  task automatic t_unselected;
    for (int b = 0; b < 7; b++) if (b != 1) frame(b, 1'b1);
    check("R5 other paths ignored", 16'h0502);
  endtask

  task automatic t_hold;
    repeat (20) @(negedge clk);
    check("R9 value holds while observed", 16'h0502);
  endtask

  task automatic t_switch;
    write_sel(3'b101);
    check("R8 switch keeps counts", 16'h0502);
    frame(1, 1'b1);
    check("R8 old path no longer counted", 16'h0502);
    frame(4, 1'b1);
    check("R8 new path bit 4 counted", 16'h0603);
  endtask

  task automatic t_clear;
    write_sel(3'b000);
    check("R6 clear on zero select", 16'h0000);
    frame(4, 1'b1); frame(1, 1'b1);
    check("R5 select zero ignores strobes", 16'h0000);
  endtask

  task automatic t_saturate;
    write_sel(3'b111);
    for (int i = 0; i < 300; i++) frame(6, 1'b1);
    check("R7 both counts stop at 255", 16'hFFFF);
    write_sel(3'b000);
    write_sel(3'b001);
    for (int i = 0; i < 260; i++) frame(0, i < 10);
    check("R7 frame saturates, errors keep own value", 16'hFF0A);
    write_sel(3'b000);
    check("R6 clear after saturation", 16'h0000);
  endtask

  initial begin
    t_reset();
    t_copper_count();
    t_unselected();
    t_hold();
    t_switch();
    t_clear();
    t_saturate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule